// File: doc/BRIEF.md
# Link Mode Sequencer Control Registers

This block is the software-facing control and status register file for a multi-rate Ethernet link sequencer. A host reaches it over a simple word-addressed bus with separate write and read strobes. Read data comes back one cycle after the read strobe, marked by a valid flag. The block holds the persistent configuration: the forced data mode, the FEC enable and request bits, timer disables, and the auto-negotiation and link-training enables. These settings drive level outputs towards the sequencer, the negotiation logic and the training logic, which are outside this block.

Command bits are self-clearing. They turn one write into a single-cycle pulse on a dedicated output and always read back as zero. A forced mode and a changed FEC request only reach the sequencer when a sequencer reset pulse fires, so the sequencer never sees a half-applied configuration. The status side latches events. An auto-negotiation timeout stays set until the sequencer reports a negotiation restart. The page-received, remote-fault-advertised and link-up flags clear when their register is read.

Top module: `lnkseq_csr`

Word map: 0 = sequencer control, 1 = sequencer status, 2 = negotiation control, 3 = negotiation commands, 4 = negotiation status, 5 = training control, 6 = training command. Every other address is unmapped.

## Requirements
- R1: After reset every register reads 0, except negotiation control bit 0 (negotiation enable) and training control bit 0 (training enable), which read 1; the FEC enable (word 0 bit 16) resets to the FEC_EN_RST parameter (default 0); all pulse outputs and `mode_force_o` are 0.
- R2: A read strobe in cycle N gives `bus_rvalid` high with the addressed word on `bus_rdata` in cycle N+1 only; without a read `bus_rvalid` is low.
- R3: Writable fields read back as written: word 0 bits 1,2,3 (timer off, link-fault timer off, fail on BER), 7:4 (mode field), 8 (calibration), 16,17,18 (FEC enable, FEC error indication, FEC request); word 2 bits 3:0; word 5 bit 0. Command bits always read 0.
- R4: Writing 1 to word 0 bit 0 raises `seq_reset_o` for exactly the one cycle after the write.
- R5: Writing 1 to word 3 bit 0, bit 4 or bit 8 pulses `an_reset_o`, `an_tx_restart_o` or `an_np_ready_o` for one cycle; writing 1 to word 6 bit 0 pulses `lt_restart_o` for one cycle.
- R6: The mode field accepts only 0000 (none), 0001 (GbE), 0010 (XAUI), 0100 (10G base-R), 0101 (10G backplane), 1100 (10G backplane with FEC); a write with any other code leaves the field unchanged while the rest of word 0 is still written.
- R7: `mode_force_o` and `fec_req_o` take the stored mode field and FEC request only in the cycle after a `seq_reset_o` pulse, and hold otherwise.
- R8: Word 1 bit 1 (negotiation timeout) sets on `an_timeout_evt_i`, stays set, and clears only on `an_restart_i`; when both arrive in the same cycle the bit ends set.
- R9: Word 4 bits 1 (page received), 3 (remote fault advertised) and 6 (link up) set on their event inputs and clear after a read of word 4, which returns the pre-clear value; an event in the same cycle as the read leaves the bit set.
- R10: Writes to unmapped addresses change no register, and reads of them return 0 with `bus_rvalid` high.
- R11: Level outputs follow their stored control bits in the cycle after the write, and word 1 bits 0, 2 and 13:8 and word 4 bits 2 and 4 show their status inputs live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| seq_link_ready_i | input | 1 | Sequencer link ready (live) |
| seq_lt_timeout_i | input | 1 | Sequencer training timeout (live) |
| seq_reconfig_mode_i | input | 6 | Sequencer reconfiguration mode (live) |
| an_timeout_evt_i | input | 1 | Negotiation timeout event |
| an_restart_i | input | 1 | Sequencer restarted negotiation |
| an_page_rx_evt_i | input | 1 | Page received event |
| an_rf_adv_evt_i | input | 1 | Remote fault advertised event |
| an_link_up_evt_i | input | 1 | Link up event |
| an_complete_i | input | 1 | Negotiation complete (live) |
| an_rx_idle_i | input | 1 | Negotiation receiver idle (live) |
| seq_reset_o | output | 1 | Sequencer reset pulse |
| mode_force_o | output | 4 | Applied forced mode |
| fec_req_o | output | 1 | Applied FEC request |
| fec_en_o | output | 1 | FEC enable |
| fec_err_ind_o | output | 1 | FEC error indication enable |
| an_tmr_off_o | output | 1 | Negotiation timer disable |
| lf_tmr_off_o | output | 1 | Link-fault timer disable |
| fail_ber_o | output | 1 | Treat non-zero final BER as failure |
| cal_en_o | output | 1 | Calibration during reconfiguration |
| an_en_o | output | 1 | Negotiation enable |
| an_user_base_o | output | 1 | Use host-supplied base pages |
| an_user_next_o | output | 1 | Use host-supplied next pages |
| an_local_rf_o | output | 1 | Signal local remote fault |
| an_reset_o | output | 1 | Negotiation reset pulse |
| an_tx_restart_o | output | 1 | Negotiation transmit restart pulse |
| an_np_ready_o | output | 1 | Next page ready pulse |
| lt_en_o | output | 1 | Training enable |
| lt_restart_o | output | 1 | Training restart pulse |

## Verification
Two pairs of functions can fall in the same cycle. A status event can coincide with the read that clears its flag, and a negotiation timeout can coincide with the restart that clears it. The bench raises the event input in the very cycle the read strobe or restart is applied. It expects the read to return the old value, and the next read to return 1, because the event must win over the clear. A mode write can also carry the sequencer reset bit in the same word. The bench then checks that the pulse applies the newly stored mode one cycle later.

// File: rtl/lnkseq_csr_pkg.sv
package lnkseq_csr_pkg;

    // word indices of the map
    localparam int unsigned REG_SEQ_CTRL = 0;
    localparam int unsigned REG_SEQ_STAT = 1;
    localparam int unsigned REG_AN_CTRL  = 2;
    localparam int unsigned REG_AN_CMD   = 3;
    localparam int unsigned REG_AN_STAT  = 4;
    localparam int unsigned REG_LT_CTRL  = 5;
    localparam int unsigned REG_LT_CMD   = 6;
    localparam int unsigned NUM_REGS     = 7;

    // sequencer control bit positions
    localparam int unsigned SC_RESET    = 0;
    localparam int unsigned SC_AN_TMR   = 1;
    localparam int unsigned SC_LF_TMR   = 2;
    localparam int unsigned SC_FAIL_BER = 3;
    localparam int unsigned SC_MODE_LO  = 4;
    localparam int unsigned SC_CAL      = 8;
    localparam int unsigned SC_FEC_EN   = 16;
    localparam int unsigned SC_FEC_ERR  = 17;
    localparam int unsigned SC_FEC_REQ  = 18;

    // sequencer status bit positions
    localparam int unsigned SS_LINK     = 0;
    localparam int unsigned SS_AN_TO    = 1;
    localparam int unsigned SS_LT_TO    = 2;
    localparam int unsigned SS_MODE_LO  = 8;

    // negotiation control bit positions
    localparam int unsigned AC_EN       = 0;
    localparam int unsigned AC_BASE     = 1;
    localparam int unsigned AC_NEXT     = 2;
    localparam int unsigned AC_RF       = 3;

    // negotiation command bit positions
    localparam int unsigned AK_RESET    = 0;
    localparam int unsigned AK_TX_RST   = 4;
    localparam int unsigned AK_NP       = 8;

    // negotiation status bit positions
    localparam int unsigned AS_PAGE     = 1;
    localparam int unsigned AS_DONE     = 2;
    localparam int unsigned AS_RF       = 3;
    localparam int unsigned AS_IDLE     = 4;
    localparam int unsigned AS_LINK     = 6;

    // training bit positions
    localparam int unsigned LC_EN       = 0;
    localparam int unsigned LK_RESTART  = 0;

    // pulse channel indices
    localparam int unsigned PL_SEQ      = 0;
    localparam int unsigned PL_AN_RST   = 1;
    localparam int unsigned PL_AN_TX    = 2;
    localparam int unsigned PL_AN_NP    = 3;
    localparam int unsigned PL_LT       = 4;
    localparam int unsigned NUM_PULSE   = 5;

    // sticky status indices
    localparam int unsigned ST_AN_TO    = 0;
    localparam int unsigned ST_PAGE     = 1;
    localparam int unsigned ST_RF       = 2;
    localparam int unsigned ST_LINK     = 3;
    localparam int unsigned NUM_STICKY  = 4;

    localparam int unsigned MODE_W      = 4;
    localparam int unsigned RCFG_W      = 6;

    typedef enum logic [MODE_W-1:0] {
        MODE_NONE      = 4'b0000,
        MODE_GBE       = 4'b0001,
        MODE_XAUI      = 4'b0010,
        MODE_10G_R     = 4'b0100,
        MODE_10G_BP    = 4'b0101,
        MODE_10G_BPFEC = 4'b1100
    } mode_e;

    function automatic logic mode_is_legal(input logic [MODE_W-1:0] code);
        case (code)
            MODE_NONE, MODE_GBE, MODE_XAUI,
            MODE_10G_R, MODE_10G_BP, MODE_10G_BPFEC: return 1'b1;
            default:                                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/lnkseq_csr_dec.sv
module lnkseq_csr_dec #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_REGS = 7
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic                rd_i,
    output logic [NUM_REGS-1:0] wr_sel_o,
    output logic [NUM_REGS-1:0] rd_sel_o
);

    logic [NUM_REGS-1:0] hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
        assign hit[i]      = (addr_i == ADDR_W'(i));
        assign wr_sel_o[i] = wr_i && hit[i];
        assign rd_sel_o[i] = rd_i && hit[i];
    end

endmodule

// File: rtl/lnkseq_csr_pulse.sv
module lnkseq_csr_pulse #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire_i,
    output logic [N-1:0] pulse_o
);

    typedef struct packed {
        logic [N-1:0] p;
    } pulse_t;

    pulse_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        st_d.p = fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.p;

endmodule

// File: rtl/lnkseq_csr_sticky.sv
module lnkseq_csr_sticky #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    typedef struct packed {
        logic [N-1:0] f;
    } sticky_t;

    sticky_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set_i[i]) begin
                st_d.f[i] = 1'b1;
            end else if (clr_i[i]) begin
                st_d.f[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.f;

endmodule

// File: rtl/lnkseq_csr.sv
module lnkseq_csr
    import lnkseq_csr_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter bit          FEC_EN_RST = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    input  logic                 seq_link_ready_i,
    input  logic                 seq_lt_timeout_i,
    input  logic [5:0]           seq_reconfig_mode_i,
    input  logic                 an_timeout_evt_i,
    input  logic                 an_restart_i,
    input  logic                 an_page_rx_evt_i,
    input  logic                 an_rf_adv_evt_i,
    input  logic                 an_link_up_evt_i,
    input  logic                 an_complete_i,
    input  logic                 an_rx_idle_i,
    output logic                 seq_reset_o,
    output logic [3:0]           mode_force_o,
    output logic                 fec_req_o,
    output logic                 fec_en_o,
    output logic                 fec_err_ind_o,
    output logic                 an_tmr_off_o,
    output logic                 lf_tmr_off_o,
    output logic                 fail_ber_o,
    output logic                 cal_en_o,
    output logic                 an_en_o,
    output logic                 an_user_base_o,
    output logic                 an_user_next_o,
    output logic                 an_local_rf_o,
    output logic                 an_reset_o,
    output logic                 an_tx_restart_o,
    output logic                 an_np_ready_o,
    output logic                 lt_en_o,
    output logic                 lt_restart_o
);

    localparam int unsigned MODE_HI = SC_MODE_LO + MODE_W - 1;
    localparam int unsigned RCFG_HI = SS_MODE_LO + RCFG_W - 1;

    typedef struct packed {
        logic              an_tmr_off;
        logic              lf_tmr_off;
        logic              fail_ber;
        logic [MODE_W-1:0] mode_field;
        logic              cal_en;
        logic              fec_en;
        logic              fec_err_ind;
        logic              fec_req_field;
        logic              an_en;
        logic              an_user_base;
        logic              an_user_next;
        logic              an_local_rf;
        logic              lt_en;
        logic [MODE_W-1:0] mode_applied;
        logic              fec_req_applied;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [NUM_REGS-1:0]   wr_sel;
    logic [NUM_REGS-1:0]   rd_sel;
    logic [NUM_PULSE-1:0]  pulse_fire;
    logic [NUM_PULSE-1:0]  pulse_out;
    logic [NUM_STICKY-1:0] stk_set;
    logic [NUM_STICKY-1:0] stk_clr;
    logic [NUM_STICKY-1:0] stk_flag;
    logic [DATA_W-1:0]     reg_word [NUM_REGS];
    logic [DATA_W-1:0]     rd_word;
    logic                  stat_an_to;
    logic                  unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // address decode
    lnkseq_csr_dec #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_dec (
        .addr_i   (bus_addr),
        .wr_i     (bus_wr),
        .rd_i     (bus_rd),
        .wr_sel_o (wr_sel),
        .rd_sel_o (rd_sel)
    );

    // self-clearing command bits
    always_comb begin
        pulse_fire            = '0;
        pulse_fire[PL_SEQ]    = wr_sel[REG_SEQ_CTRL] && bus_wdata[SC_RESET];
        pulse_fire[PL_AN_RST] = wr_sel[REG_AN_CMD]   && bus_wdata[AK_RESET];
        pulse_fire[PL_AN_TX]  = wr_sel[REG_AN_CMD]   && bus_wdata[AK_TX_RST];
        pulse_fire[PL_AN_NP]  = wr_sel[REG_AN_CMD]   && bus_wdata[AK_NP];
        pulse_fire[PL_LT]     = wr_sel[REG_LT_CMD]   && bus_wdata[LK_RESTART];
    end

    lnkseq_csr_pulse #(
        .N       (NUM_PULSE)
    ) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (pulse_fire),
        .pulse_o (pulse_out)
    );

    // latched status: set beats clear
    always_comb begin
        stk_set           = '0;
        stk_clr           = '0;
        stk_set[ST_AN_TO] = an_timeout_evt_i;
        stk_clr[ST_AN_TO] = an_restart_i;
        stk_set[ST_PAGE]  = an_page_rx_evt_i;
        stk_clr[ST_PAGE]  = rd_sel[REG_AN_STAT];
        stk_set[ST_RF]    = an_rf_adv_evt_i;
        stk_clr[ST_RF]    = rd_sel[REG_AN_STAT];
        stk_set[ST_LINK]  = an_link_up_evt_i;
        stk_clr[ST_LINK]  = rd_sel[REG_AN_STAT];
    end

    lnkseq_csr_sticky #(
        .N      (NUM_STICKY)
    ) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stk_set),
        .clr_i  (stk_clr),
        .flag_o (stk_flag)
    );

    assign stat_an_to = stk_flag[ST_AN_TO];

    // assemble readable words
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            reg_word[i] = '0;
        end
        reg_word[REG_SEQ_CTRL][SC_AN_TMR]          = r_q.an_tmr_off;
        reg_word[REG_SEQ_CTRL][SC_LF_TMR]          = r_q.lf_tmr_off;
        reg_word[REG_SEQ_CTRL][SC_FAIL_BER]        = r_q.fail_ber;
        reg_word[REG_SEQ_CTRL][MODE_HI:SC_MODE_LO] = r_q.mode_field;
        reg_word[REG_SEQ_CTRL][SC_CAL]             = r_q.cal_en;
        reg_word[REG_SEQ_CTRL][SC_FEC_EN]          = r_q.fec_en;
        reg_word[REG_SEQ_CTRL][SC_FEC_ERR]         = r_q.fec_err_ind;
        reg_word[REG_SEQ_CTRL][SC_FEC_REQ]         = r_q.fec_req_field;

        reg_word[REG_SEQ_STAT][SS_LINK]            = seq_link_ready_i;
        reg_word[REG_SEQ_STAT][SS_AN_TO]           = stk_flag[ST_AN_TO];
        reg_word[REG_SEQ_STAT][SS_LT_TO]           = seq_lt_timeout_i;
        reg_word[REG_SEQ_STAT][RCFG_HI:SS_MODE_LO] = seq_reconfig_mode_i;

        reg_word[REG_AN_CTRL][AC_EN]               = r_q.an_en;
        reg_word[REG_AN_CTRL][AC_BASE]             = r_q.an_user_base;
        reg_word[REG_AN_CTRL][AC_NEXT]             = r_q.an_user_next;
        reg_word[REG_AN_CTRL][AC_RF]               = r_q.an_local_rf;

        reg_word[REG_AN_STAT][AS_PAGE]             = stk_flag[ST_PAGE];
        reg_word[REG_AN_STAT][AS_DONE]             = an_complete_i;
        reg_word[REG_AN_STAT][AS_RF]               = stk_flag[ST_RF];
        reg_word[REG_AN_STAT][AS_IDLE]             = an_rx_idle_i;
        reg_word[REG_AN_STAT][AS_LINK]             = stk_flag[ST_LINK];

        reg_word[REG_LT_CTRL][LC_EN]               = r_q.lt_en;
    end

    // one-hot read mux; unmapped addresses select nothing
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_sel[i]) begin
                rd_word = rd_word | reg_word[i];
            end
        end
    end

    // next-state computation
    always_comb begin
        r_d = r_q;

        if (wr_sel[REG_SEQ_CTRL]) begin
            r_d.an_tmr_off    = bus_wdata[SC_AN_TMR];
            r_d.lf_tmr_off    = bus_wdata[SC_LF_TMR];
            r_d.fail_ber      = bus_wdata[SC_FAIL_BER];
            r_d.cal_en        = bus_wdata[SC_CAL];
            r_d.fec_en        = bus_wdata[SC_FEC_EN];
            r_d.fec_err_ind   = bus_wdata[SC_FEC_ERR];
            r_d.fec_req_field = bus_wdata[SC_FEC_REQ];
            if (mode_is_legal(bus_wdata[MODE_HI:SC_MODE_LO])) begin
                r_d.mode_field = bus_wdata[MODE_HI:SC_MODE_LO];
            end
        end

        if (wr_sel[REG_AN_CTRL]) begin
            r_d.an_en        = bus_wdata[AC_EN];
            r_d.an_user_base = bus_wdata[AC_BASE];
            r_d.an_user_next = bus_wdata[AC_NEXT];
            r_d.an_local_rf  = bus_wdata[AC_RF];
        end

        if (wr_sel[REG_LT_CTRL]) begin
            r_d.lt_en = bus_wdata[LC_EN];
        end

        // configuration reaches the sequencer only through its reset pulse
        if (pulse_out[PL_SEQ]) begin
            r_d.mode_applied    = r_q.mode_field;
            r_d.fec_req_applied = r_q.fec_req_field;
        end

        r_d.rvalid = bus_rd;
        r_d.rdata  = bus_rd ? rd_word : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q        <= '0;
            r_q.an_en  <= 1'b1;
            r_q.lt_en  <= 1'b1;
            r_q.fec_en <= FEC_EN_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata       = r_q.rdata;
    assign bus_rvalid      = r_q.rvalid;
    assign seq_reset_o     = pulse_out[PL_SEQ];
    assign an_reset_o      = pulse_out[PL_AN_RST];
    assign an_tx_restart_o = pulse_out[PL_AN_TX];
    assign an_np_ready_o   = pulse_out[PL_AN_NP];
    assign lt_restart_o    = pulse_out[PL_LT];
    assign mode_force_o    = r_q.mode_applied;
    assign fec_req_o       = r_q.fec_req_applied;
    assign fec_en_o        = r_q.fec_en;
    assign fec_err_ind_o   = r_q.fec_err_ind;
    assign an_tmr_off_o    = r_q.an_tmr_off;
    assign lf_tmr_off_o    = r_q.lf_tmr_off;
    assign fail_ber_o      = r_q.fail_ber;
    assign cal_en_o        = r_q.cal_en;
    assign an_en_o         = r_q.an_en;
    assign an_user_base_o  = r_q.an_user_base;
    assign an_user_next_o  = r_q.an_user_next;
    assign an_local_rf_o   = r_q.an_local_rf;
    assign lt_en_o         = r_q.lt_en;

endmodule

// File: rtl/lnkseq_csr_chk.sv
module lnkseq_csr_chk
    import lnkseq_csr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_rvalid,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              seq_reset_o,
    input logic              an_reset_o,
    input logic              an_tx_restart_o,
    input logic              an_np_ready_o,
    input logic              lt_restart_o,
    input logic [3:0]        mode_force_o,
    input logic              fec_req_o,
    input logic              an_timeout_evt_i,
    input logic              an_restart_i,
    input logic              stat_an_to
);

    // R2
    rd_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    // R2
    no_rd_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);

    // R4
    seq_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_reset_o |=> !seq_reset_o);

    // R5
    cmd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (an_reset_o || an_tx_restart_o || an_np_ready_o || lt_restart_o)
        |=> !(an_reset_o || an_tx_restart_o || an_np_ready_o || lt_restart_o));

    // R6
    applied_mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_is_legal(mode_force_o));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_reset_o |=> $stable(mode_force_o));

    // R7
    fec_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_reset_o |=> $stable(fec_req_o));

    // R8
    an_to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        an_timeout_evt_i |=> stat_an_to);

    // R8
    an_to_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_an_to && !an_restart_i) |=> stat_an_to);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr >= ADDR_W'(NUM_REGS))) |=> (bus_rdata == '0));

endmodule

bind lnkseq_csr lnkseq_csr_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .bus_addr         (bus_addr),
    .bus_rd           (bus_rd),
    .bus_rvalid       (bus_rvalid),
    .bus_rdata        (bus_rdata),
    .seq_reset_o      (seq_reset_o),
    .an_reset_o       (an_reset_o),
    .an_tx_restart_o  (an_tx_restart_o),
    .an_np_ready_o    (an_np_ready_o),
    .lt_restart_o     (lt_restart_o),
    .mode_force_o     (mode_force_o),
    .fec_req_o        (fec_req_o),
    .an_timeout_evt_i (an_timeout_evt_i),
    .an_restart_i     (an_restart_i),
    .stat_an_to       (stat_an_to)
);

// File: tb/lnkseq_csr_bench.sv
module lnkseq_csr_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          bus_rvalid;
    logic          seq_link_ready_i = 1'b0;
    logic          seq_lt_timeout_i = 1'b0;
    logic [5:0]    seq_reconfig_mode_i = '0;
    logic          an_timeout_evt_i = 1'b0;
    logic          an_restart_i = 1'b0;
    logic          an_page_rx_evt_i = 1'b0;
    logic          an_rf_adv_evt_i = 1'b0;
    logic          an_link_up_evt_i = 1'b0;
    logic          an_complete_i = 1'b0;
    logic          an_rx_idle_i = 1'b0;
    logic          seq_reset_o;
    logic [3:0]    mode_force_o;
    logic          fec_req_o, fec_en_o, fec_err_ind_o, an_tmr_off_o, lf_tmr_off_o;
    logic          fail_ber_o, cal_en_o, an_en_o, an_user_base_o, an_user_next_o;
    logic          an_local_rf_o, an_reset_o, an_tx_restart_o, an_np_ready_o;
    logic          lt_en_o, lt_restart_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lnkseq_csr u_lnkseq_csr (
        .clk (clk), .rst_n (rst_n),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
        .seq_link_ready_i (seq_link_ready_i), .seq_lt_timeout_i (seq_lt_timeout_i),
        .seq_reconfig_mode_i (seq_reconfig_mode_i),
        .an_timeout_evt_i (an_timeout_evt_i), .an_restart_i (an_restart_i),
        .an_page_rx_evt_i (an_page_rx_evt_i), .an_rf_adv_evt_i (an_rf_adv_evt_i),
        .an_link_up_evt_i (an_link_up_evt_i), .an_complete_i (an_complete_i),
        .an_rx_idle_i (an_rx_idle_i),
        .seq_reset_o (seq_reset_o), .mode_force_o (mode_force_o), .fec_req_o (fec_req_o),
        .fec_en_o (fec_en_o), .fec_err_ind_o (fec_err_ind_o),
        .an_tmr_off_o (an_tmr_off_o), .lf_tmr_off_o (lf_tmr_off_o),
        .fail_ber_o (fail_ber_o), .cal_en_o (cal_en_o), .an_en_o (an_en_o),
        .an_user_base_o (an_user_base_o), .an_user_next_o (an_user_next_o),
        .an_local_rf_o (an_local_rf_o), .an_reset_o (an_reset_o),
        .an_tx_restart_o (an_tx_restart_o), .an_np_ready_o (an_np_ready_o),
        .lt_en_o (lt_en_o), .lt_restart_o (lt_restart_o)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R2 rvalid after read", {31'd0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic bit legal_code(input int c);
        return (c == 0) || (c == 1) || (c == 2) || (c == 4) || (c == 5) || (c == 12);
    endfunction

    function automatic logic [4:0] pulses();
        return {seq_reset_o, an_reset_o, an_tx_restart_o, an_np_ready_o, lt_restart_o};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [DW-1:0] rd;
        logic [DW-1:0] exp_ctrl;
        int            prev_mode;

        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        check("R1 an_en_o", {31'd0, an_en_o}, 32'd1);
        check("R1 lt_en_o", {31'd0, lt_en_o}, 32'd1);
        check("R1 pulses", {27'd0, pulses()}, 32'd0);
        check("R1 mode_force_o", {28'd0, mode_force_o}, 32'd0);
        check("R1 fec_req_o", {31'd0, fec_req_o}, 32'd0);
        bus_read(0, rd); check("R1 seq ctrl", rd, 32'h0);
        bus_read(1, rd); check("R1 seq stat", rd, 32'h0);
        bus_read(2, rd); check("R1 an ctrl", rd, 32'h1);
        bus_read(4, rd); check("R1 an stat", rd, 32'h0);
        bus_read(5, rd); check("R1 lt ctrl", rd, 32'h1);

        // R2 valid lasts one cycle only
        @(posedge clk); #1;
        check("R2 rvalid drops", {31'd0, bus_rvalid}, 32'd0);

        // R3 / R11 readback and level outputs
        bus_write(0, 32'h0007_010E);
        check("R11 an_tmr_off_o", {31'd0, an_tmr_off_o}, 32'd1);
        check("R11 fec_en_o", {31'd0, fec_en_o}, 32'd1);
        check("R11 cal_en_o", {31'd0, cal_en_o}, 32'd1);
        bus_read(0, rd); check("R3 seq ctrl readback", rd, 32'h0007_010E);
        bus_write(2, 32'h0000_000E);
        check("R11 an_en_o cleared", {31'd0, an_en_o}, 32'd0);
        check("R11 an_local_rf_o", {31'd0, an_local_rf_o}, 32'd1);
        bus_read(2, rd); check("R3 an ctrl readback", rd, 32'hE);
        bus_write(2, 32'h1); bus_read(2, rd); check("R3 an ctrl restore", rd, 32'h1);
        bus_write(5, 32'h0);
        check("R11 lt_en_o cleared", {31'd0, lt_en_o}, 32'd0);
        bus_read(5, rd); check("R3 lt ctrl readback", rd, 32'h0);
        bus_write(5, 32'h1);
        bus_write(0, 32'h0);

        // R4 sequencer reset pulse
        bus_write(0, 32'h1);
        check("R4 pulse high", {27'd0, pulses()}, 32'h10);
        @(posedge clk); #1;
        check("R4 pulse gone", {27'd0, pulses()}, 32'h0);
        bus_read(0, rd); check("R3 reset bit reads 0", rd, 32'h0);

        // R5 command pulses
        bus_write(3, 32'h1);
        check("R5 an reset pulse", {27'd0, pulses()}, 32'h08);
        @(posedge clk); #1; check("R5 an reset clears", {27'd0, pulses()}, 32'h0);
        bus_write(3, 32'h10);
        check("R5 tx restart pulse", {27'd0, pulses()}, 32'h04);
        @(posedge clk); #1; check("R5 tx restart clears", {27'd0, pulses()}, 32'h0);
        bus_write(3, 32'h100);
        check("R5 next page pulse", {27'd0, pulses()}, 32'h02);
        @(posedge clk); #1; check("R5 next page clears", {27'd0, pulses()}, 32'h0);
        bus_write(6, 32'h1);
        check("R5 training restart pulse", {27'd0, pulses()}, 32'h01);
        @(posedge clk); #1; check("R5 training restart clears", {27'd0, pulses()}, 32'h0);
        bus_read(3, rd); check("R3 an cmd reads 0", rd, 32'h0);
        bus_read(6, rd); check("R3 lt cmd reads 0", rd, 32'h0);

        // R6 sweep of all mode codes, with a neighbour bit written alongside
        prev_mode = 0;
        for (int c = 0; c < 16; c++) begin
            bus_write(0, (32'(c) << 4) | 32'h100);
            if (legal_code(c)) prev_mode = c;
            bus_read(0, rd);
            check($sformatf("R6 mode code %0d", c), rd, (32'(prev_mode) << 4) | 32'h100);
        end
        check("R7 sweep did not apply", {28'd0, mode_force_o}, 32'd0);

        // R7 application only via sequencer reset
        bus_write(0, 32'h0004_0050);
        idle(3);
        check("R7 mode held", {28'd0, mode_force_o}, 32'd0);
        check("R7 fec req held", {31'd0, fec_req_o}, 32'd0);
        bus_write(0, 32'h0004_0051);
        check("R7 not yet applied", {28'd0, mode_force_o}, 32'd0);
        @(posedge clk); #1;
        check("R7 mode applied", {28'd0, mode_force_o}, 32'd5);
        check("R7 fec req applied", {31'd0, fec_req_o}, 32'd1);
        exp_ctrl = 32'h0000_00C1;
        bus_write(0, exp_ctrl);
        @(posedge clk); #1;
        check("R7 mode 12 applied", {28'd0, mode_force_o}, 32'd12);
        check("R7 fec req dropped", {31'd0, fec_req_o}, 32'd0);

        // R8 latched timeout
        @(negedge clk); an_timeout_evt_i = 1'b1;
        @(negedge clk); an_timeout_evt_i = 1'b0;
        idle(4);
        bus_read(1, rd); check("R8 timeout latched", rd, 32'h2);
        @(negedge clk); an_timeout_evt_i = 1'b1; an_restart_i = 1'b1;
        @(negedge clk); an_timeout_evt_i = 1'b0; an_restart_i = 1'b0;
        bus_read(1, rd); check("R8 event beats restart", rd, 32'h2);
        @(negedge clk); an_restart_i = 1'b1;
        @(negedge clk); an_restart_i = 1'b0;
        bus_read(1, rd); check("R8 restart clears", rd, 32'h0);

        // R11 live status fields
        seq_link_ready_i = 1'b1; seq_lt_timeout_i = 1'b1; seq_reconfig_mode_i = 6'h25;
        an_complete_i = 1'b1; an_rx_idle_i = 1'b1;
        bus_read(1, rd); check("R11 seq stat live", rd, 32'h0000_2505);
        bus_read(4, rd); check("R11 an stat live", rd, 32'h14);
        seq_link_ready_i = 1'b0; seq_lt_timeout_i = 1'b0; seq_reconfig_mode_i = '0;
        an_complete_i = 1'b0; an_rx_idle_i = 1'b0;

        // R9 clear-on-read, three flags
        for (int k = 0; k < 3; k++) begin
            logic [DW-1:0] m;
            m = (k == 0) ? 32'h2 : (k == 1) ? 32'h8 : 32'h40;
            @(negedge clk);
            an_page_rx_evt_i = (k == 0); an_rf_adv_evt_i = (k == 1); an_link_up_evt_i = (k == 2);
            @(negedge clk);
            an_page_rx_evt_i = 0; an_rf_adv_evt_i = 0; an_link_up_evt_i = 0;
            bus_read(4, rd); check($sformatf("R9 flag %0d set", k), rd, m);
            bus_read(4, rd); check($sformatf("R9 flag %0d cleared", k), rd, 32'h0);
            // event in the same cycle as the clearing read
            @(negedge clk);
            bus_addr = 4; bus_rd = 1'b1;
            an_page_rx_evt_i = (k == 0); an_rf_adv_evt_i = (k == 1); an_link_up_evt_i = (k == 2);
            @(negedge clk);
            bus_rd = 1'b0;
            an_page_rx_evt_i = 0; an_rf_adv_evt_i = 0; an_link_up_evt_i = 0;
            check($sformatf("R9 flag %0d old value", k), bus_rdata, 32'h0);
            bus_read(4, rd); check($sformatf("R9 flag %0d event wins", k), rd, m);
            bus_read(4, rd); check($sformatf("R9 flag %0d clears again", k), rd, 32'h0);
        end

        // R10 unmapped addresses
        for (int a = 7; a < 256; a++) begin
            bus_write(8'(a), 32'hFFFF_FFFF);
            check("R10 no pulse on unmapped write", {27'd0, pulses()}, 32'h0);
            bus_read(8'(a), rd);
            check($sformatf("R10 read of %0d", a), rd, 32'h0);
        end
        bus_read(0, rd); check("R10 seq ctrl untouched", rd, exp_ctrl & 32'hFFFF_FFFE);
        bus_read(2, rd); check("R10 an ctrl untouched", rd, 32'h1);
        bus_read(5, rd); check("R10 lt ctrl untouched", rd, 32'h1);
        check("R10 mode untouched", {28'd0, mode_force_o}, 32'd12);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule